// File: doc/BRIEF.md
# Power Domain State Controller

This block controls one switchable power domain made of a logic area and three memory banks. Software programs a target power state (ON or OFF) and, when needed, a low-power change request. A sequencer moves the domain between ON and OFF through two transitional states. It reacts to a sleep request input, which is sampled on its rising edge, and to a wake request input, which is sampled as a level. The power switch is modelled as a level request output paired with an acknowledge input. The switch answers after a fixed latency.

Software reads the domain status through a small register bus. The status holds the current power state, the logic state, a transition-in-progress flag, the per-bank memory state and the last state entered. A separate register keeps context-lost flags, which software clears by writing 1. The status and context registers are initialised only by a cold reset. The control register also returns to its defaults on a warm reset.

The low-power change request handles one specific case. The sleep edge may arrive while the target is ON, so the domain stays powered while the sleep request remains high. Software can later set the target to OFF together with this request bit, and the domain then powers down without waking first.

Top module: `pwr_dom_ctl`

## Requirements
- R1: After cold reset the control register (offset 0x0) reads 0x0003F003. Its fields are target in [1:0]=3, low-power request in [8]=0, and three read-only bank on-state fields in [17:12], all 3. The status register (offset 0x4) reads 0x00003F07. Its fields are power state [1:0]=3, logic-on [2]=1, in-transition [4]=0, bank k status at [9+2k:8+2k]=3, and last state [17:16]=0. The context register (offset 0x24) reads 0xF, with flip-flop context lost in [0] and bank k lost in [1+k].
- R2: A rising edge of the sleep request while ON with target 0 (OFF) starts powering down, so the switch request drops and the in-transition flag reads 1 after that clock edge. With target 3 the same edge changes nothing.
- R3: Powering down ends once the switch acknowledge reads 0. On entry to OFF the power state, logic-on bit and bank statuses become 0, the last-state field becomes 0, every context-lost flag becomes 1 and the in-transition flag clears.
- R4: While OFF, the wake request starts powering up with the switch request high. When the acknowledge reads 1 the domain is ON, with power state 3, logic-on 1 and all bank statuses 3.
- R5: If the domain is ON with the sleep request still high after its edge, writing target 0 with the low-power request bit set starts powering down without a new sleep edge. The request bit clears when OFF is entered.
- R6: A low-power request written while the domain is ON with the sleep request low has no effect. It reads 1 just after the write and 0 one clock later.
- R7: A software write of 3 to the last-state field sets it to 3. Writes of any other value leave it unchanged.
- R8: Writing 1 to a context-lost bit clears it. Writing 0 leaves it unchanged.
- R9: A warm reset returns the control register to 0x0003F003 and leaves the status and context registers unchanged.
- R10: The bank on-state fields of the control register are read-only and keep reading 3 after any write.
- R11: A wake request during powering down does not abort it. The domain first reaches OFF, with power state 0, and then powers up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Cold reset, active low, asynchronous |
| warmRstN | input | 1 | Warm reset, active low, asynchronous |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset for write and read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| sleepReq | input | 1 | Domain sleep request, rising edge sensitive |
| wakeReq | input | 1 | Domain wake request, level sensitive |
| swOnReq | output | 1 | Power switch request, 1 means power on |
| swAck | input | 1 | Power switch acknowledge, follows swOnReq after a fixed latency |

## Verification
The hardest situation to reach is the deeper-state path. The domain has to take a sleep edge with an ON target and then sit asleep but powered with the sleep request held high. Only in that state does the low-power request take effect. The bench raises the sleep request while the target is still 3 and confirms the switch stays on. It then writes target 0 together with the request bit. A second hard case is a wake request that arrives in the middle of powering down. The bench raises it right after the sleep edge and then polls the status each cycle to confirm the domain passes through OFF.

// File: rtl/pwr_dom_pkg.sv
package pwr_dom_pkg;
  typedef enum logic [1:0] {
    SEQ_ON   = 2'd0,
    SEQ_DOWN = 2'd1,
    SEQ_OFF  = 2'd2,
    SEQ_UP   = 2'd3
  } seqState_e;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic enterOff;
    logic enterOn;
    logic lpClr;
    logic busy;
  } seqStrb_t;

  localparam logic [1:0] PWR_OFF = 2'b00;
  localparam logic [1:0] PWR_ON  = 2'b11;

  localparam logic [7:0] OFS_CTL = 8'h00;
  localparam logic [7:0] OFS_STA = 8'h04;
  localparam logic [7:0] OFS_CTX = 8'h24;

  localparam int CTL_LP_BIT   = 8;
  localparam int CTL_ONST_LSB = 12;
  localparam int STA_LOGIC    = 2;
  localparam int STA_BUSY     = 4;
  localparam int STA_BANK_LSB = 8;
  localparam int STA_LAST_LSB = 16;
  localparam int CTX_BANK_LSB = 1;
endpackage

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pwr_dom_pkg::*;
(
  input  logic       clk,
  input  logic       coldRstN,
  input  logic       sleepReq,
  input  logic       wakeReq,
  input  logic       swAck,
  input  logic [1:0] target,
  input  logic       lpPend,
  output logic       swOnReq,
  output seqStrb_t   strb
);
  seqState_e state, stateNxt;
  logic sleepQ;
  logic sleepRise;
  logic goDown;

  assign sleepRise = sleepReq & ~sleepQ;
  assign goDown = (target == PWR_OFF) && (sleepRise || (sleepReq && lpPend));

  always_comb begin
    stateNxt = state;
    strb = '0;
    unique case (state)
      SEQ_ON: begin
        if (goDown) stateNxt = SEQ_DOWN;
        strb.lpClr = ~sleepReq;
      end
      SEQ_DOWN: begin
        strb.busy = 1'b1;
        if (!swAck) begin
          stateNxt = SEQ_OFF;
          strb.enterOff = 1'b1;
          strb.lpClr = 1'b1;
        end
      end
      SEQ_OFF: begin
        if (wakeReq) stateNxt = SEQ_UP;
      end
      SEQ_UP: begin
        strb.busy = 1'b1;
        if (swAck) begin
          stateNxt = SEQ_ON;
          strb.enterOn = 1'b1;
        end
      end
      default: stateNxt = SEQ_ON;
    endcase
  end

  assign swOnReq = (state == SEQ_ON) || (state == SEQ_UP);

  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      state  <= SEQ_ON;
      sleepQ <= 1'b0;
    end else begin
      state  <= stateNxt;
      sleepQ <= sleepReq;
    end
  end
endmodule

// File: rtl/pwr_dom_regs.sv
module pwr_dom_regs
  import pwr_dom_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                   clk,
  input  logic                   coldRstN,
  input  logic                   warmRstN,
  input  logic                   regWrEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWrData,
  input  seqStrb_t               strb,
  output logic [DATA_W-1:0]      regRdData,
  output logic [1:0]             target,
  output logic                   lpPend,
  output logic [1:0]             pwrStat,
  output logic [2*NUM_BANKS-1:0] bankStat,
  output logic [NUM_BANKS:0]     ctxLost,
  output logic [1:0]             lastState
);
  localparam int BANK_W = 2 * NUM_BANKS;
  localparam int CTX_W  = NUM_BANKS + 1;

  logic ctlRstN;
  logic wrCtl, wrSta, wrCtx;
  logic logicOn;
  logic [DATA_W-1:0] ctlWord, staWord, ctxWord;

  assign ctlRstN = coldRstN & warmRstN;
  assign wrCtl = regWrEn && (regAddr == ADDR_W'(OFS_CTL));
  assign wrSta = regWrEn && (regAddr == ADDR_W'(OFS_STA));
  assign wrCtx = regWrEn && (regAddr == ADDR_W'(OFS_CTX));

  // control register: cold or warm reset
  always_ff @(posedge clk or negedge ctlRstN) begin
    if (!ctlRstN) begin
      target <= PWR_ON;
      lpPend <= 1'b0;
    end else if (wrCtl) begin
      target <= regWrData[1:0];
      lpPend <= regWrData[CTL_LP_BIT];
    end else if (strb.lpClr) begin
      lpPend <= 1'b0;
    end
  end

  // status and context: cold reset only
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      pwrStat   <= PWR_ON;
      logicOn   <= 1'b1;
      bankStat  <= '1;
      lastState <= PWR_OFF;
      ctxLost   <= '1;
    end else if (strb.enterOff) begin
      pwrStat   <= PWR_OFF;
      logicOn   <= 1'b0;
      bankStat  <= '0;
      lastState <= PWR_OFF;
      ctxLost   <= '1;
    end else begin
      if (strb.enterOn) begin
        pwrStat  <= PWR_ON;
        logicOn  <= 1'b1;
        bankStat <= '1;
      end
      if (wrSta && regWrData[STA_LAST_LSB +: 2] == PWR_ON) lastState <= PWR_ON;
      if (wrCtx) ctxLost <= ctxLost & ~regWrData[CTX_W-1:0];
    end
  end

  always_comb begin
    ctlWord = '0;
    ctlWord[1:0] = target;
    ctlWord[CTL_LP_BIT] = lpPend;
    ctlWord[CTL_ONST_LSB +: BANK_W] = '1;

    staWord = '0;
    staWord[1:0] = pwrStat;
    staWord[STA_LOGIC] = logicOn;
    staWord[STA_BUSY] = strb.busy;
    staWord[STA_BANK_LSB +: BANK_W] = bankStat;
    staWord[STA_LAST_LSB +: 2] = lastState;

    ctxWord = '0;
    ctxWord[CTX_W-1:0] = ctxLost;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_W'(OFS_CTL): regRdData = ctlWord;
      ADDR_W'(OFS_STA): regRdData = staWord;
      ADDR_W'(OFS_CTX): regRdData = ctxWord;
      default:          regRdData = '0;
    endcase
  end
endmodule

// File: rtl/pwr_dom_ctl.sv
module pwr_dom_ctl
  import pwr_dom_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              warmRstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sleepReq,
  input  logic              wakeReq,
  output logic              swOnReq,
  input  logic              swAck
);
  seqStrb_t strb;
  logic [1:0] target;
  logic lpPend;
  logic [1:0] pwrStat;
  logic [2*NUM_BANKS-1:0] bankStat;
  logic [NUM_BANKS:0] ctxLost;
  logic [1:0] lastState;

  pwr_dom_seq u_seq (
    .clk      (clk),
    .coldRstN (coldRstN),
    .sleepReq (sleepReq),
    .wakeReq  (wakeReq),
    .swAck    (swAck),
    .target   (target),
    .lpPend   (lpPend),
    .swOnReq  (swOnReq),
    .strb     (strb)
  );

  pwr_dom_regs #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_regs (
    .clk       (clk),
    .coldRstN  (coldRstN),
    .warmRstN  (warmRstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb),
    .regRdData (regRdData),
    .target    (target),
    .lpPend    (lpPend),
    .pwrStat   (pwrStat),
    .bankStat  (bankStat),
    .ctxLost   (ctxLost),
    .lastState (lastState)
  );
endmodule

// File: rtl/pwr_dom_chk.sv
module pwr_dom_chk
  import pwr_dom_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                   clk,
  input logic                   coldRstN,
  input logic                   regWrEn,
  input logic [ADDR_W-1:0]      regAddr,
  input logic [DATA_W-1:0]      regWrData,
  input logic                   sleepReq,
  input logic                   swOnReq,
  input logic                   swAck,
  input seqStrb_t               strb,
  input logic                   lpPend,
  input logic [1:0]             pwrStat,
  input logic [2*NUM_BANKS-1:0] bankStat,
  input logic [NUM_BANKS:0]     ctxLost,
  input logic [1:0]             lastState
);
  // R3
  off_entry_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    strb.enterOff |=> (pwrStat == PWR_OFF && bankStat == '0 && (&ctxLost) && lastState == PWR_OFF));

  // R4
  on_entry_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    strb.enterOn |=> (pwrStat == PWR_ON && (&bankStat)));

  // R6
  lp_drop_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    (lpPend && swOnReq && !strb.busy && !sleepReq && !(regWrEn && regAddr == ADDR_W'(OFS_CTL)))
      |=> !lpPend);

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    (strb.busy && swOnReq == swAck) |=> !strb.busy);

  // R7
  last_keep_chk: assert property (@(posedge clk) disable iff (!coldRstN)
    (regWrEn && regAddr == ADDR_W'(OFS_STA) && regWrData[STA_LAST_LSB +: 2] != PWR_ON && !strb.enterOff)
      |=> $stable(lastState));
endmodule

bind pwr_dom_ctl pwr_dom_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk       (clk),
  .coldRstN  (coldRstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .sleepReq  (sleepReq),
  .swOnReq   (swOnReq),
  .swAck     (swAck),
  .strb      (strb),
  .lpPend    (lpPend),
  .pwrStat   (pwrStat),
  .bankStat  (bankStat),
  .ctxLost   (ctxLost),
  .lastState (lastState)
);

// File: tb/tb_pwr_dom_ctl.sv
module tb_pwr_dom_ctl;
  localparam int ACK_LAT = 4;
  localparam int NVEC = 8;
  localparam logic [7:0] A_CTL = 8'h00, A_STA = 8'h04, A_CTX = 8'h24;

  logic clk = 1'b0;
  logic coldRstN = 1'b0, warmRstN = 1'b1;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic sleepReq = 1'b0, wakeReq = 1'b0;
  logic swOnReq, swAck;
  logic [ACK_LAT-1:0] ackPipe;
  int nChk = 0, nBad = 0, cyc = 0;

  always #10 clk = ~clk;

  // switch model: acknowledge follows the request after ACK_LAT cycles
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) ackPipe <= '1;
    else ackPipe <= {ackPipe[ACK_LAT-2:0], swOnReq};
  end
  assign swAck = ackPipe[ACK_LAT-1];

  pwr_dom_ctl dut (
    .clk(clk), .coldRstN(coldRstN), .warmRstN(warmRstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .swOnReq(swOnReq), .swAck(swAck)
  );

  // {addr, write data, expected read of same addr after write}
  localparam logic [71:0] VEC [NVEC] = '{
    {A_CTL, 32'h0000_0003, 32'h0003_F003},   // R10
    {A_STA, 32'h0001_0000, 32'h0000_3F07},   // R7 value 1 ignored
    {A_STA, 32'h0002_0000, 32'h0000_3F07},   // R7 value 2 ignored
    {A_STA, 32'h0003_0000, 32'h0003_3F07},   // R7 value 3 taken
    {A_CTX, 32'h0000_0000, 32'h0000_000F},   // R8 zero ignored
    {A_CTX, 32'h0000_0002, 32'h0000_000D},   // R8
    {A_CTX, 32'h0000_0009, 32'h0000_0004},   // R8
    {A_CTL, 32'h0000_0001, 32'h0003_F001}    // R10 with reserved target
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      rdReg(A_STA, s);
      if (!s[4]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    while (cyc < 100000) begin
      @(posedge clk); cyc++;
    end
    nChk++; nBad++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic sawOff;
    repeat (3) @(negedge clk);
    coldRstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(A_CTL, r); check("R1 ctl", r, 32'h0003_F003);
    rdReg(A_STA, r); check("R1 sta", r, 32'h0000_3F07);
    rdReg(A_CTX, r); check("R1 ctx", r, 32'h0000_000F);

    for (int i = 0; i < NVEC; i++) begin
      wrReg(VEC[i][71:64], VEC[i][63:32]);
      rdReg(VEC[i][71:64], r);
      check("R7/R8/R10 table", r, VEC[i][31:0]);
    end

    // R6: low-power request while awake ON
    wrReg(A_CTL, 32'h0000_0103);
    rdReg(A_CTL, r); check("R6 just written", r, 32'h0003_F103);
    @(negedge clk);
    rdReg(A_CTL, r); check("R6 self cleared", r, 32'h0003_F003);
    check("R6 still on", {31'b0, swOnReq}, 32'h1);

    // R2: sleep edge with target ON changes nothing
    sleepReq = 1'b1;
    @(negedge clk);
    rdReg(A_STA, r);
    check("R2 target on, no transition", {30'b0, swOnReq, r[4]}, 32'h2);

    // R5: deeper state while asleep
    wrReg(A_CTL, 32'h0000_0100);
    @(negedge clk);
    rdReg(A_STA, r);
    check("R5 going down", {30'b0, swOnReq, r[4]}, 32'h1);
    waitIdle();
    rdReg(A_STA, r); check("R3 off status", r, 32'h0000_0000);
    rdReg(A_CTX, r); check("R3 ctx all lost", r, 32'h0000_000F);
    rdReg(A_CTL, r); check("R5 request cleared", r, 32'h0003_F000);

    // new sleep edge while OFF is ignored
    sleepReq = 1'b0; @(negedge clk);
    sleepReq = 1'b1; @(negedge clk); @(negedge clk);
    rdReg(A_STA, r); check("R11 sleep edge in off", r, 32'h0000_0000);
    sleepReq = 1'b0;

    // R4 wake
    wakeReq = 1'b1; @(negedge clk); wakeReq = 1'b0;
    rdReg(A_STA, r);
    check("R4 going up", {30'b0, swOnReq, r[4]}, 32'h3);
    waitIdle();
    rdReg(A_STA, r); check("R4 on status", r, 32'h0000_3F07);

    // R2 + R11: sleep edge with target OFF, wake arrives mid-way
    sleepReq = 1'b1; @(negedge clk);
    rdReg(A_STA, r);
    check("R2 going down", {30'b0, swOnReq, r[4]}, 32'h1);
    wakeReq = 1'b1;
    sawOff = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      rdReg(A_STA, r);
      if (r[1:0] == 2'b00) sawOff = 1'b1;
      if (sawOff && !r[4] && r[1:0] == 2'b11) break;
    end
    check("R11 passed through off", {31'b0, sawOff}, 32'h1);
    check("R11 back on", r, 32'h0000_3F07);
    wakeReq = 1'b0; sleepReq = 1'b0;

    // R9 warm reset
    wrReg(A_CTX, 32'h0000_000F);
    wrReg(A_STA, 32'h0003_0000);
    wrReg(A_CTL, 32'h0000_0000);
    warmRstN = 1'b0; @(negedge clk); warmRstN = 1'b1; @(negedge clk);
    rdReg(A_CTL, r); check("R9 ctl default", r, 32'h0003_F003);
    rdReg(A_STA, r); check("R9 sta kept", r, 32'h0003_3F07);
    rdReg(A_CTX, r); check("R9 ctx kept", r, 32'h0000_0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule